// File: doc/BRIEF.md
# Push-Button Frequency Step Controller

This block holds the target frequency of a phase-locked local oscillator as a whole number of megahertz. The reference is divided down to a 1 MHz comparison rate, so the feedback divide ratio N equals the frequency in MHz. The block splits N into the two counter values of a dual-modulus divider with a fixed prescaler of 8, using N = 8·B + A.

Two raw push-button inputs raise or lower the frequency by 1 MHz, within a window of 70 to 90 MHz. Each button is debounced before use. Every accepted change asks the serial configuration block for a reload with a one-clock strobe. While that block reports busy, the request waits. The current frequency is also driven out for a numeric display.

Top module: `freq_step_ctrl`

## Requirements
- R1: While reset is held and just after it, the frequency output is 70, `cnt_a` is 6 and `cnt_b` is 8. Exactly one reload strobe follows reset.
- R2: A debounced press of the up button (a rising edge of its filtered level) raises the frequency by exactly 1 and produces exactly one reload strobe.
- R3: A debounced press of the down button lowers the frequency by exactly 1 and produces exactly one reload strobe.
- R4: `cnt_b` always equals the frequency divided by 8, rounded down, and `cnt_a` always equals the frequency modulo 8. So `cnt_a` stays below 8.
- R5: An up press at 90 MHz leaves the frequency at 90 and produces no reload strobe.
- R6: A down press at 70 MHz leaves the frequency at 70 and produces no reload strobe.
- R7: A raw button level shorter than `DEB_CLKS` clocks has no effect on the frequency and produces no reload strobe.
- R8: A button held down for a long time gives only one step.
- R9: A step accepted while `cfg_busy` is high changes the frequency at once. Its reload strobe is held back until `cfg_busy` is low, and it is then issued once.
- R10: `reload_req` is never high in the clock that follows a clock in which `cfg_busy` was high.
- R11: If up and down presses are accepted in the same clock, the frequency does not change and no reload strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_up_raw | input | 1 | Raw up button level, active high |
| btn_dn_raw | input | 1 | Raw down button level, active high |
| cfg_busy | input | 1 | Serial configuration block is busy |
| cnt_a | output | A_W | Swallow counter value (N mod 8) |
| cnt_b | output | B_W | Main counter value (N / 8) |
| reload_req | output | 1 | One-clock reload request strobe |
| freq_mhz | output | FREQ_W | Current frequency in MHz |

## Verification
The bound checker watches every clock for these rules: the frequency stays inside its window, it moves by no more than one per clock and only when a filtered edge is accepted, the counter split matches the frequency, and no strobe appears just after a busy clock. The checker cannot show how long a press must last before it counts, that a held button steps only once, or that a delayed request is later issued exactly once. The bench covers these cases by counting strobes around glitches, long holds, presses at both window edges, presses while busy and presses on both buttons at once.

// File: rtl/freq_step_pkg.sv
package freq_step_pkg;
  // Main counter: N divided by the prescaler (2**plog2)
  function automatic int main_count(input int n, input int plog2);
    return n >> plog2;
  endfunction

  // Swallow counter: remainder of N by the prescaler
  function automatic int swallow_count(input int n, input int plog2);
    return n & ((1 << plog2) - 1);
  endfunction
endpackage

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int DEB_CLKS = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic press
);
  localparam int CNT_W = $clog2(DEB_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEB_CLKS - 1);

  logic [1:0]       sync_q;
  logic             level_q;
  logic             level_d;
  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b00;
      level_q <= 1'b0;
      level_d <= 1'b0;
      run_q   <= '0;
    end else begin
      sync_q  <= {sync_q[0], raw};
      level_d <= level_q;
      if (sync_q[1] == level_q) begin
        run_q <= '0;
      end else if (run_q == LAST) begin
        level_q <= sync_q[1];
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // one-clock pulse on the rising edge of the filtered level
  assign press = level_q & ~level_d;
endmodule

// File: rtl/freq_track.sv
module freq_track #(
  parameter int FREQ_W = 7,
  parameter int F_MIN  = 70,
  parameter int F_MAX  = 90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_step,
  input  logic              dn_step,
  output logic [FREQ_W-1:0] freq,
  output logic              stepped
);
  localparam logic [FREQ_W-1:0] LO = FREQ_W'(F_MIN);
  localparam logic [FREQ_W-1:0] HI = FREQ_W'(F_MAX);

  logic go_up;
  logic go_dn;

  assign go_up   = up_step & ~dn_step & (freq < HI);
  assign go_dn   = dn_step & ~up_step & (freq > LO);
  assign stepped = go_up | go_dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     freq <= LO;
    else if (go_up) freq <= freq + 1'b1;
    else if (go_dn) freq <= freq - 1'b1;
  end
endmodule

// File: rtl/reload_ctrl.sv
module reload_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic stepped,
  input  logic cfg_busy,
  output logic reload_req
);
  logic pending_q;
  logic issue;

  assign issue = pending_q & ~cfg_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q  <= 1'b1;   // initial load after reset
      reload_req <= 1'b0;
    end else begin
      reload_req <= issue;
      pending_q  <= (pending_q & ~issue) | stepped;
    end
  end
endmodule

// File: rtl/freq_step_ctrl.sv
module freq_step_ctrl #(
  parameter int FREQ_W     = 7,
  parameter int A_W        = 6,
  parameter int B_W        = 13,
  parameter int PRESC_LOG2 = 3,
  parameter int F_MIN      = 70,
  parameter int F_MAX      = 90,
  parameter int DEB_CLKS   = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              btn_up_raw,
  input  logic              btn_dn_raw,
  input  logic              cfg_busy,
  output logic [A_W-1:0]    cnt_a,
  output logic [B_W-1:0]    cnt_b,
  output logic              reload_req,
  output logic [FREQ_W-1:0] freq_mhz
);
  import freq_step_pkg::*;

  localparam int NBTN = 2;

  logic [NBTN-1:0] raw_vec;
  logic [NBTN-1:0] press_vec;
  logic            up_step;
  logic            dn_step;
  logic            stepped;

  assign raw_vec = {btn_dn_raw, btn_up_raw};

  for (genvar i = 0; i < NBTN; i++) begin : g_btn
    btn_debounce #(.DEB_CLKS(DEB_CLKS)) u_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw_vec[i]),
      .press (press_vec[i])
    );
  end

  assign up_step = press_vec[0];
  assign dn_step = press_vec[1];

  freq_track #(.FREQ_W(FREQ_W), .F_MIN(F_MIN), .F_MAX(F_MAX)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_step (up_step),
    .dn_step (dn_step),
    .freq    (freq_mhz),
    .stepped (stepped)
  );

  reload_ctrl u_rld (
    .clk        (clk),
    .rst_n      (rst_n),
    .stepped    (stepped),
    .cfg_busy   (cfg_busy),
    .reload_req (reload_req)
  );

  assign cnt_b = B_W'(main_count(int'(freq_mhz), PRESC_LOG2));
  assign cnt_a = A_W'(swallow_count(int'(freq_mhz), PRESC_LOG2));
endmodule

// File: rtl/freq_step_chk.sv
module freq_step_chk #(
  parameter int FREQ_W = 7,
  parameter int A_W    = 6,
  parameter int B_W    = 13,
  parameter int F_MIN  = 70,
  parameter int F_MAX  = 90
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_busy,
  input logic              up_step,
  input logic              dn_step,
  input logic [A_W-1:0]    cnt_a,
  input logic [B_W-1:0]    cnt_b,
  input logic              reload_req,
  input logic [FREQ_W-1:0] freq_mhz
);
  localparam logic [FREQ_W-1:0] LO = FREQ_W'(F_MIN);
  localparam logic [FREQ_W-1:0] HI = FREQ_W'(F_MAX);

  // R5 R6
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_mhz >= LO) && (freq_mhz <= HI));

  // R4
  split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_a < A_W'(8)) && ((32'(cnt_b) * 8 + 32'(cnt_a)) == 32'(freq_mhz)));

  // R2
  up_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_step && !dn_step && freq_mhz < HI) |=> (freq_mhz == $past(freq_mhz) + 1'b1));

  // R3
  dn_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_step && !up_step && freq_mhz > LO) |=> (freq_mhz == $past(freq_mhz) - 1'b1));

  // R5
  top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_mhz == HI && up_step && !dn_step) |=> (freq_mhz == HI));

  // R6
  bottom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_mhz == LO && dn_step && !up_step) |=> (freq_mhz == LO));

  // R11
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_step && dn_step) |=> $stable(freq_mhz));

  // R8
  no_step_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_step && !dn_step) |=> $stable(freq_mhz));

  // R10
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_busy |=> !reload_req);
endmodule

bind freq_step_ctrl freq_step_chk #(
  .FREQ_W(FREQ_W), .A_W(A_W), .B_W(B_W), .F_MIN(F_MIN), .F_MAX(F_MAX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_busy   (cfg_busy),
  .up_step    (up_step),
  .dn_step    (dn_step),
  .cnt_a      (cnt_a),
  .cnt_b      (cnt_b),
  .reload_req (reload_req),
  .freq_mhz   (freq_mhz)
);

// File: tb/sim_freq_step_ctrl.sv
`timescale 1ns/1ps
module sim_freq_step_ctrl;
  localparam int DEB  = 4;
  localparam int SETL = DEB + 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       up_raw = 1'b0;
  logic       dn_raw = 1'b0;
  logic       busy = 1'b0;
  logic [5:0] cnt_a;
  logic [12:0] cnt_b;
  logic       reload_req;
  logic [6:0] freq;

  int total = 0;
  int bad = 0;
  int rel_cnt = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  freq_step_ctrl #(.DEB_CLKS(DEB)) u0 (
    .clk(clk), .rst_n(rst_n), .btn_up_raw(up_raw), .btn_dn_raw(dn_raw),
    .cfg_busy(busy), .cnt_a(cnt_a), .cnt_b(cnt_b),
    .reload_req(reload_req), .freq_mhz(freq)
  );

  always @(posedge clk) begin
    if (rst_n && reload_req) rel_cnt++;
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  // press: 0 = up, 1 = down, 2 = both
  task automatic press(input int which, input int hold);
    @(negedge clk);
    if (which != 1) up_raw = 1'b1;
    if (which != 0) dn_raw = 1'b1;
    wait_clks(hold);
    up_raw = 1'b0;
    dn_raw = 1'b0;
    wait_clks(SETL);
  endtask

  task automatic chk_split(input string req, input int f);
    chk(req, int'(cnt_b), f / 8);
    chk(req, int'(cnt_a), f % 8);
  endtask

  localparam bit STIM_DN[8]  = '{0, 0, 0, 1, 0, 1, 1, 1};
  localparam int STIM_EXP[8] = '{71, 72, 73, 72, 73, 72, 71, 70};

  initial begin
    int r0;
    wait_clks(3);
    // R1 during reset
    chk("R1", int'(freq), 70);
    chk("R1", int'(cnt_a), 6);
    chk("R1", int'(cnt_b), 8);
    rst_n = 1'b1;
    wait_clks(6);
    chk("R1", rel_cnt, 1);
    chk("R1", int'(freq), 70);

    // table walk: R2 R3 R4
    for (int k = 0; k < 8; k++) begin
      r0 = rel_cnt;
      press(STIM_DN[k] ? 1 : 0, SETL);
      chk(STIM_DN[k] ? "R3" : "R2", int'(freq), STIM_EXP[k]);
      chk(STIM_DN[k] ? "R3" : "R2", rel_cnt - r0, 1);
      chk_split("R4", STIM_EXP[k]);
    end

    // climb to the top window edge
    r0 = rel_cnt;
    for (int k = 0; k < 20; k++) press(0, SETL);
    chk("R2", int'(freq), 90);
    chk("R2", rel_cnt - r0, 20);
    chk_split("R4", 90);
    // R5 up at 90
    r0 = rel_cnt;
    press(0, SETL);
    chk("R5", int'(freq), 90);
    chk("R5", rel_cnt - r0, 0);

    for (int k = 0; k < 20; k++) press(1, SETL);
    chk("R3", int'(freq), 70);
    // R6 down at 70
    r0 = rel_cnt;
    press(1, SETL);
    chk("R6", int'(freq), 70);
    chk("R6", rel_cnt - r0, 0);

    // R7 short glitch
    r0 = rel_cnt;
    press(0, 2);
    chk("R7", int'(freq), 70);
    chk("R7", rel_cnt - r0, 0);

    // R8 long hold
    r0 = rel_cnt;
    press(0, 200);
    chk("R8", int'(freq), 71);
    chk("R8", rel_cnt - r0, 1);

    // R9 step while busy
    busy = 1'b1;
    r0 = rel_cnt;
    press(0, SETL);
    chk("R9", int'(freq), 72);
    chk_split("R9", 72);
    wait_clks(20);
    chk("R9", rel_cnt - r0, 0);
    busy = 1'b0;
    wait_clks(4);
    chk("R9", rel_cnt - r0, 1);

    // R11 both at once
    r0 = rel_cnt;
    press(2, SETL);
    chk("R11", int'(freq), 72);
    chk("R11", rel_cnt - r0, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule